// File: doc/BRIEF.md
# Windowed Keyed Watchdog Timer

This block supervises a processor by counting instruction-cycle ticks and expecting software to prove it is alive by writing a service word. A service only counts when it carries a hidden five-bit key and lands inside a window. That window is no sooner than a minimum number of ticks after the window last restarted, and no later than an upper limit that software picks at its first service. Writes with the wrong key, writes that change the settings latched at the first service, writes that arrive too early and windows that run out all produce a one-cycle error pulse. The system's reset logic uses this pulse to act.

While the core is in HALT or IDLE, the tick counter freezes and error detection is switched off. A pulse marking the exit from IDLE acts as a hardware service that restarts the window. The service register can be read back: it shows the latched window and monitor settings but never the key. Register access is a plain strobe with no handshake, so there is no back-pressure. A write strobe is consumed in the cycle it is presented. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `wdt_keyed_watchdog`

## Requirements
- R1: A service word is laid out as key in bits [7:3], window select in bits [2:1] and monitor enable in bit [0]. The key is 5'b01100. A write whose key differs raises `wdog_err` in the next cycle.
- R2: A read returns {5'b00000, window select, monitor enable} one cycle after `rd_en`, so the key is never visible. Out of reset the window select is 2'b11 and the monitor enable is 0, so a read returns 8'h06.
- R3: The first correctly keyed write after reset is accepted whatever the tick count. It latches the window select and monitor enable and restarts the window.
- R4: After the first service, a write whose window select or monitor enable differs from the latched values raises an error. The latched values do not change on that write, or on any other error.
- R5: After the first service, a correctly keyed and matching write that arrives while fewer than MIN_WAIT (default 2048) ticks have been counted since the window restarted raises an error. It does not restart the window.
- R6: After the first service, a correctly keyed and matching write with at least MIN_WAIT ticks counted is valid and restarts the window at zero ticks.
- R7: The upper limit is 2^(WIN_BASE_LOG2+sel) ticks, which by default gives 8192, 16384, 32768 or 65536 for window select 0 to 3. Out of reset the limit is the largest one. The tick that reaches the limit with no service raises an error and restarts the window.
- R8: Ticks advance the counter only while `tick_en` is high. While `halt_mode` or `idle_mode` is high, the counter holds, writes are ignored and no error is raised.
- R9: `idle_exit` restarts the window as a service, without an error. A write in the same cycle is ignored, so a write soon after it is early (R5).
- R10: `wdog_err` is registered. It rises one clock after the cycle that caused the error and lasts one cycle per error event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One instruction-cycle tick |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service word: key, window select, monitor enable |
| rd_en | input | 1 | Service register read strobe |
| rd_data | output | 8 | Read-back word; key field reads as zero |
| halt_mode | input | 1 | Core is in HALT |
| idle_mode | input | 1 | Core is in IDLE |
| idle_exit | input | 1 | One-cycle pulse when IDLE ends |
| wdog_err | output | 1 | One-cycle watchdog error pulse |

## Verification
The bench builds the block with MIN_WAIT of 16 and WIN_BASE_LOG2 of 6. With these values the four upper limits become 64, 128, 256 and 512 ticks. Expiry at every window size, the early and late edges of the window, and the freeze across HALT and IDLE can then be reached many times over in a short run. Directed cases cover the exact tick on which expiry fires and the reset-time limit. Random traffic mixes key, field, early-service and low-power events against a cycle model built from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [4:0] WDT_KEY = 5'b01100;

  typedef struct packed {
    logic [4:0] key;
    logic [1:0] sel;
    logic       mon;
  } wdt_word_t;
endpackage

// File: rtl/wdt_window_counter.sv
module wdt_window_counter #(
  parameter int MIN_WAIT      = 2048,
  parameter int WIN_BASE_LOG2 = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       run,
  input  logic [1:0]                 sel,
  output logic [WIN_BASE_LOG2+2:0]   cnt,
  output logic                       expire,
  output logic                       early
);
  localparam int CNT_W = WIN_BASE_LOG2 + 3;

  logic [CNT_W-1:0] lim_m1 [4];
  logic [CNT_W-1:0] cnt_q;

  // last count value of each selectable window
  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_m1[g] = CNT_W'((64'd1 << (WIN_BASE_LOG2 + g)) - 64'd1);
  end

  assign expire = run && (cnt_q == lim_m1[sel]);
  assign early  = (cnt_q < CNT_W'(MIN_WAIT));
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= expire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_service_judge.sv
module wdt_service_judge
  import wdt_pkg::*;
(
  input  logic      req,
  input  wdt_word_t word,
  input  logic      first_done,
  input  logic [1:0] win_q,
  input  logic      mon_q,
  input  logic      early,
  output logic      accept,
  output logic      fault
);
  logic key_ok, fields_ok;

  assign key_ok    = (word.key == WDT_KEY);
  assign fields_ok = (word.sel == win_q) && (word.mon == mon_q);
  // first service: key only; later ones: fields must match and window must be open
  assign accept    = req && key_ok && (!first_done || (fields_ok && !early));
  assign fault     = req && !accept;
endmodule

// File: rtl/wdt_keyed_watchdog.sv
module wdt_keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int MIN_WAIT      = 2048,
  parameter int WIN_BASE_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       halt_mode,
  input  logic       idle_mode,
  input  logic       idle_exit,
  output logic       wdog_err
);
  localparam int CNT_W = WIN_BASE_LOG2 + 3;

  wdt_word_t        wr_word;
  logic             lowpwr, wr_act, run;
  logic             svc_ok, svc_err, expire, early;
  logic [CNT_W-1:0] cnt_q;
  logic             first_q, mon_q, err_q;
  logic [1:0]       win_q;
  logic [7:0]       rd_q;

  assign wr_word = wr_data;
  assign lowpwr  = halt_mode || idle_mode;
  assign wr_act  = wr_en && !lowpwr && !idle_exit;
  assign run     = tick_en && !lowpwr && !wr_act && !idle_exit;

  wdt_window_counter #(
    .MIN_WAIT      (MIN_WAIT),
    .WIN_BASE_LOG2 (WIN_BASE_LOG2)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (idle_exit || svc_ok),
    .run     (run),
    .sel     (win_q),
    .cnt     (cnt_q),
    .expire  (expire),
    .early   (early)
  );

  wdt_service_judge u_judge (
    .req        (wr_act),
    .word       (wr_word),
    .first_done (first_q),
    .win_q      (win_q),
    .mon_q      (mon_q),
    .early      (early),
    .accept     (svc_ok),
    .fault      (svc_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      win_q   <= 2'b11;
      mon_q   <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= 8'h00;
    end else begin
      err_q <= svc_err || expire;
      if (svc_ok && !first_q) begin
        first_q <= 1'b1;
        win_q   <= wr_word.sel;
        mon_q   <= wr_word.mon;
      end
      if (rd_en) rd_q <= {5'b00000, win_q, mon_q};
    end
  end

  assign rd_data  = rd_q;
  assign wdog_err = err_q;
endmodule

// File: rtl/wdt_keyed_watchdog_chk.sv
module wdt_keyed_watchdog_chk #(
  parameter int MIN_WAIT      = 2048,
  parameter int WIN_BASE_LOG2 = 13
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick_en,
  input logic                     wr_en,
  input logic                     halt_mode,
  input logic                     idle_mode,
  input logic                     idle_exit,
  input logic [7:0]               rd_data,
  input logic                     wdog_err,
  input logic [WIN_BASE_LOG2+2:0] cnt,
  input logic [1:0]               win,
  input logic                     mon
);
  localparam int CNT_W = WIN_BASE_LOG2 + 3;
  logic [CNT_W:0] limit;
  assign limit = (CNT_W+1)'(64'd1 << (WIN_BASE_LOG2 + int'(win)));

  p_key_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:3] == 5'b00000);

  p_fields_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_err |-> ($stable(win) && $stable(mon)));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < limit);

  p_lowpwr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_mode || idle_mode) && !idle_exit) |=> !wdog_err);

  p_lowpwr_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_mode || idle_mode) && !idle_exit) |=> $stable(cnt));

  p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en && !idle_exit) |=> $stable(cnt));

  p_idle_exit_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_exit |=> (cnt == '0) && !wdog_err);
endmodule

bind wdt_keyed_watchdog wdt_keyed_watchdog_chk #(
  .MIN_WAIT      (MIN_WAIT),
  .WIN_BASE_LOG2 (WIN_BASE_LOG2)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .wr_en     (wr_en),
  .halt_mode (halt_mode),
  .idle_mode (idle_mode),
  .idle_exit (idle_exit),
  .rd_data   (rd_data),
  .wdog_err  (wdog_err),
  .cnt       (cnt_q),
  .win       (win_q),
  .mon       (mon_q)
);

// File: tb/wdt_keyed_watchdog_test.sv
module wdt_keyed_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_WAIT   = 16;
  localparam int BASE       = 6;
  localparam int SEED       = 1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic halt_mode = 1'b0, idle_mode = 1'b0, idle_exit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic wdog_err;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int    m_cnt;
  bit    m_first;
  bit [1:0] m_sel;
  bit    m_mon;
  bit    m_err;
  bit [7:0] m_rd;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_keyed_watchdog #(.MIN_WAIT(MIN_WAIT), .WIN_BASE_LOG2(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .halt_mode(halt_mode), .idle_mode(idle_mode), .idle_exit(idle_exit),
    .wdog_err(wdog_err)
  );

  function automatic int lim(input bit [1:0] s);
    return 1 << (BASE + s);
  endfunction

  function automatic bit [7:0] svc_word(input bit [4:0] k, input bit [1:0] s, input bit m);
    return {k, s, m};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_first = 0; m_sel = 2'b11; m_mon = 0; m_err = 0; m_rd = 8'h00; m_tag = "R10";
  endtask

  task automatic model_update();
    bit lp;
    lp = halt_mode || idle_mode;
    m_err = 0; m_tag = "R10";
    if (rd_en) m_rd = {5'b0, m_sel, m_mon};
    if (idle_exit) m_cnt = 0;
    else if (wr_en && !lp) begin
      if (wr_data[7:3] != 5'b01100) begin m_err = 1; m_tag = "R1"; end
      else if (!m_first) begin
        m_first = 1; m_sel = wr_data[2:1]; m_mon = wr_data[0]; m_cnt = 0;
      end else if (wr_data[2:1] != m_sel || wr_data[0] != m_mon) begin m_err = 1; m_tag = "R4"; end
      else if (m_cnt < MIN_WAIT) begin m_err = 1; m_tag = "R5"; end
      else m_cnt = 0;
    end else if (tick_en && !lp) begin
      if (m_cnt == lim(m_sel) - 1) begin m_err = 1; m_tag = "R7"; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(wdog_err === m_err, m_tag, int'(wdog_err), int'(m_err));
    chk(rd_data === m_rd, "R2", int'(rd_data), int'(m_rd));
  endtask

  task automatic drive(input bit t, input bit w, input bit [7:0] d, input bit r,
                       input bit h, input bit i, input bit x);
    tick_en = t; wr_en = w; wr_data = d; rd_en = r;
    halt_mode = h; idle_mode = i; idle_exit = x;
    step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick_en = 0; wr_en = 0; rd_en = 0; halt_mode = 0; idle_mode = 0; idle_exit = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(SEED);
    do_reset();
    chk(wdog_err === 1'b0, "R10 reset", int'(wdog_err), 0);
    chk(rd_data === 8'h00, "R2 reset", int'(rd_data), 0);

    drive(1, 0, 8'h00, 1, 0, 0, 0);
    chk(rd_data === 8'h06, "R2 reset fields", int'(rd_data), 8'h06);
    drive(1, 1, 8'hFF, 0, 0, 0, 0);
    chk(wdog_err === 1'b1, "R1 bad key", int'(wdog_err), 1);
    drive(1, 1, svc_word(5'b01100, 2'b00, 1'b1), 0, 0, 0, 0);
    chk(wdog_err === 1'b0, "R3 first service", int'(wdog_err), 0);
    drive(1, 0, 8'h00, 1, 0, 0, 0);
    chk(rd_data === 8'h01, "R2 latched read", int'(rd_data), 8'h01);
    drive(1, 1, svc_word(5'b01100, 2'b00, 1'b1), 0, 0, 0, 0);
    chk(wdog_err === 1'b1, "R5 early service", int'(wdog_err), 1);
    for (int k = 0; k < 20; k++) drive(1, 0, 8'h00, 0, 0, 0, 0);
    drive(1, 1, svc_word(5'b01100, 2'b00, 1'b1), 0, 0, 0, 0);
    chk(wdog_err === 1'b0, "R6 valid service", int'(wdog_err), 0);
    for (int k = 0; k < 20; k++) drive(1, 0, 8'h00, 0, 0, 0, 0);
    drive(1, 1, svc_word(5'b01100, 2'b01, 1'b1), 0, 0, 0, 0);
    chk(wdog_err === 1'b1, "R4 window mismatch", int'(wdog_err), 1);
    drive(1, 1, svc_word(5'b01100, 2'b00, 1'b0), 1, 0, 0, 0);
    chk(wdog_err === 1'b1, "R4 monitor mismatch", int'(wdog_err), 1);
    drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(rd_data === 8'h01, "R4 fields kept", int'(rd_data), 8'h01);
    chk(wdog_err === 1'b0, "R10 single pulse", int'(wdog_err), 0);

    // expiry exactly on the 64th tick after a restart
    drive(1, 0, 8'h00, 0, 0, 0, 1);
    for (int k = 0; k < 63; k++) drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b0, "R7 before limit", int'(wdog_err), 0);
    drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b1, "R7 expiry", int'(wdog_err), 1);
    drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b0, "R10 pulse ends", int'(wdog_err), 0);

    // low-power freeze: bad writes and ticks have no effect
    for (int k = 0; k < 100; k++) drive(1, k == 5, 8'h00, 0, 1, k > 50, 0);
    chk(wdog_err === 1'b0, "R8 quiet in halt", int'(wdog_err), 0);
    for (int k = 0; k < 62; k++) drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b0, "R8 count held", int'(wdog_err), 0);
    drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b1, "R8 resumed expiry", int'(wdog_err), 1);
    for (int k = 0; k < 30; k++) drive(0, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b0, "R8 no tick", int'(wdog_err), 0);

    // idle exit acts as service and overrides a same-cycle write
    for (int k = 0; k < 5; k++) drive(1, 0, 8'h00, 0, 0, 1, 0);
    drive(1, 1, 8'hFF, 0, 0, 0, 1);
    chk(wdog_err === 1'b0, "R9 idle exit", int'(wdog_err), 0);
    drive(1, 1, svc_word(5'b01100, 2'b00, 1'b1), 0, 0, 0, 0);
    chk(wdog_err === 1'b1, "R9 early after exit", int'(wdog_err), 1);

    // reset-time limit is the largest window
    do_reset();
    for (int k = 0; k < lim(2'b11) - 1; k++) drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b0, "R7 reset limit before", int'(wdog_err), 0);
    drive(1, 0, 8'h00, 0, 0, 0, 0);
    chk(wdog_err === 1'b1, "R7 reset limit", int'(wdog_err), 1);

    // constrained random traffic against the model
    do_reset();
    begin
      bit h, i, x, w, t, r, pend_exit;
      bit [7:0] d;
      h = 0; i = 0; pend_exit = 0;
      for (int n = 0; n < 30000; n++) begin
        x = 0;
        if (pend_exit) begin x = 1; pend_exit = 0; end
        if (($urandom % 300) == 0) h = ~h;
        if (($urandom % 300) == 0) begin
          if (i) pend_exit = 1;
          i = ~i;
        end
        t = ($urandom % 10) < 7;
        w = ($urandom % 25) == 0;
        r = ($urandom % 8) == 0;
        d = svc_word(5'b01100, m_first ? m_sel : 2'($urandom), m_first ? m_mon : 1'($urandom));
        case ($urandom % 10)
          0: d[7:3] = 5'($urandom);
          1: d[2:1] = 2'($urandom);
          2: d[0]   = 1'($urandom);
          default: ;
        endcase
        drive(t, w, d, r, h, i, x);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule